// File: doc/BRIEF.md
# Transfer Byte Counter Tracker

This block follows a data transfer on a storage bus. Software loads a 24-bit count of bytes still to move and a 32-bit position pointer. Each time the bus datapath confirms that a byte has actually crossed the bus, it pulses a strobe. On that strobe the count steps down by one and the pointer steps up by one in the same cycle. The count therefore always reflects bytes truly completed, and the pointer always names the next byte to move. Requests that have only been issued do not move either value.

Two sticky status flags record events. One records the count reaching zero. The other records the count wrapping below zero. Each flag is cleared by writing a one to its bit, and each has its own interrupt enable. The single interrupt output is the OR of every enabled flag. All access goes through a byte-wide register port. Reads are combinational, and writes take effect at the next rising clock edge.

Top module: `xfer_count_tracker`

## Requirements
- R1: After reset the count, the pointer, both status flags and both enables are zero, and `irq` is low.
- R2: The count is written and read as three bytes at offsets 0x0 (bits 7:0), 0x1 (bits 15:8) and 0x2 (bits 23:16). A write replaces only the addressed byte.
- R3: A `xfer_done` pulse that is accepted lowers the count by exactly one at the next edge. With no accepted pulse, no write and no clear, the count holds its value.
- R4: The pointer sits at offsets 0x4 to 0x7, least significant byte first, and its bytes can be written to seed it. Each accepted `xfer_done` pulse raises it by one in the same cycle the count moves, and it wraps from 0xFFFFFFFF to 0.
- R5: Status bit 0 (done, offset 0x9) becomes 1 when an accepted pulse takes the count from 1 to 0.
- R6: An accepted pulse while the count is 0 makes the count 0xFFFFFF and sets status bit 1 (wrap). Done is not set by this step, and the pointer still advances.
- R7: Writing offset 0x8 with bit 0 set zeroes the count without touching the status flags. A write to 0x8 with bit 0 clear has no effect. Offset 0x8 reads as zero.
- R8: Writing offset 0x9 clears each status bit written as one and leaves bits written as zero unchanged. Writing 0x9 never sets a bit. If a set event and a clear of the same bit fall in one cycle, the bit ends set.
- R9: Offset 0xA bits 1:0 are the enables for wrap and done and read back as written. `irq` is high exactly when some status bit and its enable are both 1. It drops in the cycle after the last enabled flag is cleared.
- R10: A pulse in the same cycle as a host write to any count byte or pointer byte, or as a count clear, is ignored. The write or clear takes effect, and neither the count nor the pointer steps.
- R11: Offsets 0x3 and 0xB to 0xF read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| xfer_done | input | 1 | One byte confirmed transferred on the bus |
| irq | output | 1 | Interrupt, OR of enabled status flags |

## Verification
The collisions that matter are those between a byte-completion strobe and a host access in the same clock cycle. The bench drives the strobe together with a count-byte write, and again together with a count clear. It then checks that the written value or the zero stands and that the pointer did not move. A second collision pairs a write-one-to-clear of done with the strobe that takes the count from one to zero. The bench judges it by reading the status after the edge: the set must win. The wrap step from zero is checked by reading the count, the status flags and the pointer.

// File: rtl/xct_pkg.sv
package xct_pkg;

  localparam int unsigned REG_AW = 4;
  localparam int unsigned NSRC   = 2;

  localparam logic [REG_AW-1:0] OFS_CNT0 = 4'h0;
  localparam logic [REG_AW-1:0] OFS_PTR0 = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h8;
  localparam logic [REG_AW-1:0] OFS_STAT = 4'h9;
  localparam logic [REG_AW-1:0] OFS_IEN  = 4'hA;

  localparam int unsigned CTRL_CLR_BIT = 0;

  // status bit order: [1] wrap, [0] done
  typedef struct packed {
    logic wrap;
    logic done;
  } xct_ev_t;

endpackage

// File: rtl/xct_counter.sv
module xct_counter #(
  parameter int unsigned WIDTH  = 24,
  parameter bit          DOWN   = 1'b1,
  parameter int unsigned NBYTES = WIDTH / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBYTES-1:0]  byte_we,
  input  logic [7:0]         wdata,
  input  logic               clr,
  input  logic               step,
  output logic [WIDTH-1:0]   value,
  output xct_pkg::xct_ev_t   ev
);

  function automatic logic [WIDTH-1:0] next_val(input logic [WIDTH-1:0] v);
    if (DOWN) return v - WIDTH'(1);
    else      return v + WIDTH'(1);
  endfunction

  function automatic logic wraps(input logic [WIDTH-1:0] v);
    if (DOWN) return (v == '0);
    else      return (&v);
  endfunction

  logic step_go;
  logic host_hit;

  assign host_hit = clr || (|byte_we);
  assign step_go  = step && !host_hit;

  assign ev.wrap = step_go && wraps(value);
  assign ev.done = step_go && (next_val(value) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (|byte_we) begin
      for (int b = 0; b < int'(NBYTES); b++) begin
        if (byte_we[b]) value[b*8 +: 8] <= wdata;
      end
    end else if (step_go) begin
      value <= next_val(value);
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !host_hit) |=> $stable(value));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));

  generate
    if (DOWN) begin : g_down
      assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !host_hit) |=> (value == $past(value) - WIDTH'(1)));
    end else begin : g_up
      assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !host_hit) |=> (value == $past(value) + WIDTH'(1)));
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assert_byte_load_R2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we[b] && !clr) |=> (value[b*8 +: 8] == $past(wdata)));
    end
  endgenerate

endmodule

// File: rtl/xct_status.sv
module xct_status #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_ev,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] enable,
  output logic            irq
);

  logic [NSRC-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_mask) | set_ev;
      if (en_we) enable <= en_wdata;
    end
  end

  assign irq = |(status & enable);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[i] && !clr_mask[i]) |=> status[i]);
      assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask[i] && !set_ev[i]) |=> !status[i]);
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[i] |=> status[i]);
      assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[i] && !set_ev[i]) |=> !status[i]);
    end
  endgenerate

endmodule

// File: rtl/xfer_count_tracker.sv
module xfer_count_tracker #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned PTR_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       xfer_done,
  output logic       irq
);
  import xct_pkg::*;

  localparam int unsigned CNT_NB = CNT_W / 8;
  localparam int unsigned PTR_NB = PTR_W / 8;

  logic [CNT_NB-1:0] wr_cnt;
  logic [PTR_NB-1:0] wr_ptr;
  logic              clr_cnt;
  logic              host_owns;
  logic              step;
  logic [CNT_W-1:0]  cnt_value;
  logic [PTR_W-1:0]  ptr_value;
  xct_ev_t           cnt_ev;
  xct_ev_t           ptr_ev;
  logic [NSRC-1:0]   status;
  logic [NSRC-1:0]   enable;

  // write decode
  generate
    for (genvar b = 0; b < CNT_NB; b++) begin : g_wcnt
      assign wr_cnt[b] = reg_wr && (reg_addr == OFS_CNT0 + REG_AW'(b));
    end
    for (genvar b = 0; b < PTR_NB; b++) begin : g_wptr
      assign wr_ptr[b] = reg_wr && (reg_addr == OFS_PTR0 + REG_AW'(b));
    end
  endgenerate

  assign clr_cnt   = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_CLR_BIT];
  assign host_owns = (|wr_cnt) || (|wr_ptr) || clr_cnt;
  assign step      = xfer_done && !host_owns;

  xct_counter #(.WIDTH(CNT_W), .DOWN(1'b1)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (wr_cnt),
    .wdata   (reg_wdata),
    .clr     (clr_cnt),
    .step    (step),
    .value   (cnt_value),
    .ev      (cnt_ev)
  );

  xct_counter #(.WIDTH(PTR_W), .DOWN(1'b0)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (wr_ptr),
    .wdata   (reg_wdata),
    .clr     (1'b0),
    .step    (step),
    .value   (ptr_value),
    .ev      (ptr_ev)
  );

  xct_status #(.NSRC(NSRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   ({cnt_ev.wrap, cnt_ev.done}),
    .clr_we   (reg_wr && (reg_addr == OFS_STAT)),
    .clr_bits (reg_wdata[NSRC-1:0]),
    .en_we    (reg_wr && (reg_addr == OFS_IEN)),
    .en_wdata (reg_wdata[NSRC-1:0]),
    .status   (status),
    .enable   (enable),
    .irq      (irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < int'(CNT_NB); b++) begin
      if (reg_addr == OFS_CNT0 + REG_AW'(b)) reg_rdata = cnt_value[b*8 +: 8];
    end
    for (int b = 0; b < int'(PTR_NB); b++) begin
      if (reg_addr == OFS_PTR0 + REG_AW'(b)) reg_rdata = ptr_value[b*8 +: 8];
    end
    if (reg_addr == OFS_STAT) reg_rdata = 8'(status);
    if (reg_addr == OFS_IEN)  reg_rdata = 8'(enable);
  end

  assert_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ptr_value == $past(ptr_value) + PTR_W'(1)) &&
             (cnt_value == $past(cnt_value) - CNT_W'(1)));

  assert_strobe_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && host_owns && !(|wr_ptr)) |=> $stable(ptr_value));

  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ev.done |=> (cnt_value == '0) && status[0]);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ev.wrap |=> (&cnt_value) && status[1]);

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_ev.wrap || ptr_ev.done) |=> (ptr_value == '0));

  assert_clear_keeps_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cnt && !(reg_addr == OFS_STAT)) |=> (status == $past(status)));

endmodule

// File: tb/test_xfer_count_tracker.sv
`timescale 1ns/1ps
module test_xfer_count_tracker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       xfer_done;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xfer_count_tracker i_xfer_count_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .xfer_done (xfer_done),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock: optional write and optional strobe in the same cycle
  task automatic cyc(input bit wr, input logic [3:0] a, input logic [7:0] d, input bit st);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; xfer_done = st;
    @(negedge clk);
    reg_wr = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic strobe();
    cyc(1'b0, 4'h0, 8'h00, 1'b1);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr_cnt(input logic [23:0] v);
    wr(4'h0, v[7:0]); wr(4'h1, v[15:8]); wr(4'h2, v[23:16]);
  endtask

  task automatic wr_ptr(input logic [31:0] v);
    wr(4'h4, v[7:0]); wr(4'h5, v[15:8]); wr(4'h6, v[23:16]); wr(4'h7, v[31:24]);
  endtask

  task automatic rd_cnt(output logic [31:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'h0, b0); rd(4'h1, b1); rd(4'h2, b2);
    v = {8'h00, b2, b1, b0};
  endtask

  task automatic rd_ptr(output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    rd(4'h4, b0); rd(4'h5, b1); rd(4'h6, b2); rd(4'h7, b3);
    v = {b3, b2, b1, b0};
  endtask

  task automatic rd8(input logic [3:0] a, output logic [31:0] v);
    logic [7:0] b;
    rd(a, b);
    v = {24'h0, b};
  endtask

  logic [31:0] v;

  task automatic t_reset();
    rd_cnt(v);      chk("R1 count", v, 0);
    rd_ptr(v);      chk("R1 pointer", v, 0);
    rd8(4'h9, v);   chk("R1 status", v, 0);
    rd8(4'hA, v);   chk("R1 enable", v, 0);
    chk("R1 irq", {31'h0, irq}, 0);
  endtask

  task automatic t_load();
    wr_cnt(24'h123456);
    wr_ptr(32'h89ABCDEF);
    rd_cnt(v);      chk("R2 count load", v, 32'h123456);
    wr(4'h1, 8'hA5);
    rd_cnt(v);      chk("R2 single byte", v, 32'h12A556);
    wr_cnt(24'h123456);
    rd_ptr(v);      chk("R4 pointer seed", v, 32'h89ABCDEF);
  endtask

  task automatic t_decrement();
    strobe(); strobe(); strobe();
    rd_cnt(v);      chk("R3 count after 3", v, 32'h123453);
    rd_ptr(v);      chk("R4 pointer after 3", v, 32'h89ABCDF2);
    rd8(4'h9, v);   chk("R5 no done yet", v, 0);
    repeat (3) @(negedge clk);
    rd_cnt(v);      chk("R3 hold when idle", v, 32'h123453);
  endtask

  task automatic t_done();
    wr_cnt(24'h000002);
    strobe();
    rd_cnt(v);      chk("R3 count 2->1", v, 1);
    rd8(4'h9, v);   chk("R5 done not at 1", v, 0);
    strobe();
    rd_cnt(v);      chk("R5 count at 0", v, 0);
    rd8(4'h9, v);   chk("R5 done set", v, 32'h1);
  endtask

  task automatic t_wrap();
    strobe();
    rd_cnt(v);      chk("R6 count wrapped", v, 32'hFFFFFF);
    rd8(4'h9, v);   chk("R6 wrap set", v, 32'h3);
    rd_ptr(v);      chk("R6 pointer advanced", v, 32'h89ABCDF5);
    chk("R9 irq masked", {31'h0, irq}, 0);
  endtask

  task automatic t_w1c();
    wr(4'h9, 8'h00);
    rd8(4'h9, v);   chk("R8 zero write no effect", v, 32'h3);
    wr(4'h9, 8'h01);
    rd8(4'h9, v);   chk("R8 clear done only", v, 32'h2);
    wr(4'h9, 8'h02);
    rd8(4'h9, v);   chk("R8 clear wrap", v, 0);
    wr(4'h9, 8'hFF);
    rd8(4'h9, v);   chk("R8 write never sets", v, 0);
  endtask

  task automatic t_irq();
    wr(4'hA, 8'h01);
    wr(4'h8, 8'h01);
    strobe();
    rd8(4'h9, v);   chk("R6 wrap again", v, 32'h2);
    chk("R9 irq off with wrap disabled", {31'h0, irq}, 0);
    wr(4'hA, 8'h03);
    rd8(4'hA, v);   chk("R9 enable readback", v, 32'h3);
    chk("R9 irq on", {31'h0, irq}, 1);
    wr(4'h9, 8'h02);
    chk("R9 irq drops after clear", {31'h0, irq}, 0);
  endtask

  task automatic t_clear();
    wr_cnt(24'h000010);
    wr(4'h8, 8'h00);
    rd_cnt(v);      chk("R7 zero bit no clear", v, 32'h10);
    wr(4'h8, 8'hFE);
    rd_cnt(v);      chk("R7 bit0 clear only", v, 32'h10);
    wr(4'h8, 8'h01);
    rd_cnt(v);      chk("R7 count cleared", v, 0);
    rd8(4'h9, v);   chk("R7 status untouched", v, 0);
    rd8(4'h8, v);   chk("R7 control reads zero", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] p;
    wr_cnt(24'h000005);
    rd_ptr(p);
    cyc(1'b1, 4'h0, 8'h40, 1'b1);
    rd_cnt(v);      chk("R10 write beats strobe", v, 32'h40);
    rd_ptr(v);      chk("R10 pointer still", v, p);
    cyc(1'b1, 4'h8, 8'h01, 1'b1);
    rd_cnt(v);      chk("R10 clear beats strobe", v, 0);
    rd_ptr(v);      chk("R10 pointer still after clear", v, p);
    rd8(4'h9, v);   chk("R10 no wrap from dropped strobe", v, 0);
    cyc(1'b1, 4'h4, 8'h00, 1'b1);
    rd_cnt(v);      chk("R10 ptr write blocks count", v, 0);
    rd_ptr(v);      chk("R10 ptr byte written", v, {p[31:8], 8'h00});
    wr_cnt(24'h000001);
    cyc(1'b1, 4'h9, 8'h01, 1'b1);
    rd8(4'h9, v);   chk("R8 set wins over clear", v, 32'h1);
    rd_cnt(v);      chk("R5 count zero in collision", v, 0);
  endtask

  task automatic t_ptr_wrap();
    wr_ptr(32'hFFFFFFFF);
    wr_cnt(24'h000100);
    strobe();
    rd_ptr(v);      chk("R4 pointer wraps", v, 0);
    rd_cnt(v);      chk("R3 count with ptr wrap", v, 32'hFF);
  endtask

  task automatic t_unmapped();
    wr(4'h3, 8'h77);
    wr(4'hC, 8'h77);
    rd8(4'h3, v);   chk("R11 offset 3", v, 0);
    for (int a = 11; a < 16; a++) begin
      rd8(4'(a), v); chk("R11 high offset", v, 0);
    end
    rd_cnt(v);      chk("R11 count untouched", v, 32'hFF);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = 8'h00; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_decrement();
    t_done();
    t_wrap();
    t_w1c();
    t_irq();
    t_clear();
    t_collide();
    t_ptr_wrap();
    t_unmapped();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule